// File: doc/BRIEF.md
# Epoch Checkpoint Sequencer

This block ends each execution epoch by running a checkpoint across a small group of processor agents. A checkpoint starts when an internal epoch timer runs out or when an external request pulse arrives. The block then takes back execution from every agent together and steps them through three phases in a fixed order. First the agents stall and empty their volatile pipeline state. Next they write back every dirty line in their local caches. Last they save their execution context to persistent storage.

Each phase is a barrier. The block raises one request line per agent, and it waits until every agent has answered with a done pulse before it opens the next phase. When the context phase is complete, the block issues one write of a completion marker to persistent storage. The marker carries the number of the epoch that is being closed, and only this marker makes the checkpoint valid. When the marker write is acknowledged, the epoch number advances and the agents are released into the new epoch.

A request that arrives while a checkpoint is in progress does not abort or restart that checkpoint. It is held, and a new checkpoint begins as soon as the current one has released the agents.

Top module: `ckpt_sequencer`

## Requirements
- R1: After reset, `agent_run` is 1, `agent_req` is all zeros, `mark_valid` is 0 and `epoch` is 0.
- R2: If `ckpt_req` is sampled high at a rising edge while agents are running, `agent_req` is still all zeros after that edge. After the next edge, `agent_req` is all ones, `agent_phase` is 0 (drain) and `agent_run` is 0.
- R3: `agent_phase` takes the codes 0 (drain), 1 (cache write-back) and 2 (context save), in that order, once each per checkpoint.
- R4: Within a phase, an agent's `agent_req` bit clears on the edge that samples its `agent_done` pulse. The phase code holds while any request bit is still set. On the edge that samples the last outstanding done, all request bits are set again and the next phase code is shown.
- R5: A done pulse from an agent whose request bit is low has no effect. This includes the edge that opens a phase, so that agent must answer again.
- R6: `mark_valid` rises on the edge that samples the last done of the context phase, never earlier, and never while a request bit is set. It carries `mark_addr` = MARK_ADDR and `mark_data` = the current epoch number, zero-extended. It holds with stable data until `mark_ready` is high.
- R7: On the edge where `mark_valid` and `mark_ready` are both high, `epoch` increments by one, `mark_valid` falls and `agent_run` rises.
- R8: With no external request, a checkpoint starts by itself. `agent_run` stays high for exactly EPOCH_CYCLES+1 cycles, and then the requests for the drain phase appear.
- R9: A `ckpt_req` pulse during a checkpoint does not restart it, so the phase never returns to drain. After that checkpoint releases the agents, `agent_run` is high for exactly one cycle, and then a new checkpoint begins.
- R10: `agent_run` is high only when no agent request and no marker write is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ckpt_req | input | 1 | External checkpoint request pulse |
| agent_req | output | N_AGENTS | Per-agent phase request, cleared by that agent's done |
| agent_phase | output | 2 | Current phase: 0 drain, 1 cache write-back, 2 context save |
| agent_done | input | N_AGENTS | Per-agent single-cycle done pulse |
| agent_run | output | 1 | High while agents execute normally |
| mark_valid | output | 1 | Completion-marker write request |
| mark_addr | output | ADDR_W | Marker address (MARK_ADDR) |
| mark_data | output | DATA_W | Marker payload: epoch number being closed |
| mark_ready | input | 1 | Marker write acknowledge |
| epoch | output | EPOCH_W | Current epoch number |

## Verification
The properties assume that each agent answers a request with a `agent_done` pulse that lasts exactly one cycle. A done that is held high would be counted again in the next phase. The bench responders and the directed done pulses never hold done for more than one cycle. The checks for R5 drive done pulses on purpose at times when requests are low, including the edge that opens a phase. `mark_ready` may stay low for any number of cycles. The bench holds it low for several cycles to exercise the hold rule on the marker.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

  typedef enum logic [1:0] {
    PH_DRAIN = 2'd0,
    PH_FLUSH = 2'd1,
    PH_CTX   = 2'd2
  } phase_t;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_DRAIN = 3'd1,
    ST_FLUSH = 3'd2,
    ST_CTX   = 3'd3,
    ST_MARK  = 3'd4
  } state_t;

endpackage

// File: rtl/ckpt_trigger.sv
// Epoch timer plus request latch. A request is held until the sequencer
// accepts it, so a request made during a checkpoint is never lost.
module ckpt_trigger #(
  parameter int EPOCH_CYCLES = 200,
  localparam int CNT_W = $clog2(EPOCH_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic take,
  input  logic ext_req,
  output logic pending
);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = running && (cnt_q == CNT_W'(EPOCH_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (running && !expire) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else begin
      pending <= (pending && !take) || ext_req || expire;
    end
  end

endmodule

// File: rtl/ckpt_barrier.sv
// Per-agent request vector with an AND barrier over the done pulses.
module ckpt_barrier #(
  parameter int N_AGENTS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                arm,
  input  logic [N_AGENTS-1:0] done_in,
  output logic [N_AGENTS-1:0] req_q,
  output logic                all_done
);

  logic [N_AGENTS-1:0] left;

  // Agents still owing a done after this cycle's pulses.
  assign left     = req_q & ~done_in;
  assign all_done = (left == '0);

  for (genvar a = 0; a < N_AGENTS; a++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[a] <= 1'b0;
      end else if (arm) begin
        req_q[a] <= 1'b1;
      end else begin
        req_q[a] <= left[a];
      end
    end
  end

endmodule

// File: rtl/ckpt_marker.sv
// Completion-marker write port: one request, held until acknowledged.
module ckpt_marker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int EPOCH_W = 16,
  parameter logic [ADDR_W-1:0] MARK_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic [EPOCH_W-1:0] epoch_in,
  input  logic               ready,
  output logic               valid,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  data,
  output logic               fire
);

  assign addr = MARK_ADDR;
  assign fire = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (launch) begin
      valid <= 1'b1;
      data  <= DATA_W'(epoch_in);
    end else if (fire) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ckpt_sequencer.sv
module ckpt_sequencer #(
  parameter int N_AGENTS     = 4,
  parameter int EPOCH_W      = 16,
  parameter int EPOCH_CYCLES = 200,
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 64,
  parameter logic [ADDR_W-1:0] MARK_ADDR = ADDR_W'(32'h0001_F000)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ckpt_req,
  output logic [N_AGENTS-1:0] agent_req,
  output logic [1:0]          agent_phase,
  input  logic [N_AGENTS-1:0] agent_done,
  output logic                agent_run,
  output logic                mark_valid,
  output logic [ADDR_W-1:0]   mark_addr,
  output logic [DATA_W-1:0]   mark_data,
  input  logic                mark_ready,
  output logic [EPOCH_W-1:0]  epoch
);
  import ckpt_pkg::*;

  state_t state_q, state_d;
  phase_t phase_q, phase_d;
  logic   pending, take, arm, launch, fire, all_done, running;
  logic   run_q;
  logic [EPOCH_W-1:0] epoch_q;

  assign running = (state_q == ST_RUN);
  assign take    = running && pending;

  ckpt_trigger #(.EPOCH_CYCLES(EPOCH_CYCLES)) u_trig (
    .clk(clk), .rst(rst), .running(running), .take(take),
    .ext_req(ckpt_req), .pending(pending)
  );

  ckpt_barrier #(.N_AGENTS(N_AGENTS)) u_bar (
    .clk(clk), .rst(rst), .arm(arm), .done_in(agent_done),
    .req_q(agent_req), .all_done(all_done)
  );

  ckpt_marker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EPOCH_W(EPOCH_W), .MARK_ADDR(MARK_ADDR)
  ) u_mark (
    .clk(clk), .rst(rst), .launch(launch), .epoch_in(epoch_q),
    .ready(mark_ready), .valid(mark_valid), .addr(mark_addr),
    .data(mark_data), .fire(fire)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    arm     = 1'b0;
    launch  = 1'b0;
    case (state_q)
      ST_RUN: if (pending) begin
        state_d = ST_DRAIN; phase_d = PH_DRAIN; arm = 1'b1;
      end
      ST_DRAIN: if (all_done) begin
        state_d = ST_FLUSH; phase_d = PH_FLUSH; arm = 1'b1;
      end
      ST_FLUSH: if (all_done) begin
        state_d = ST_CTX; phase_d = PH_CTX; arm = 1'b1;
      end
      ST_CTX: if (all_done) begin
        state_d = ST_MARK; launch = 1'b1;
      end
      ST_MARK: if (fire) begin
        state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      phase_q <= PH_DRAIN;
      run_q   <= 1'b1;
      epoch_q <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      run_q   <= (state_d == ST_RUN);
      if (fire) epoch_q <= epoch_q + 1'b1;
    end
  end

  assign agent_phase = phase_q;
  assign agent_run   = run_q;
  assign epoch       = epoch_q;

endmodule

// File: rtl/ckpt_sequencer_chk.sv
module ckpt_sequencer_chk #(
  parameter int N_AGENTS = 4,
  parameter int EPOCH_W  = 16,
  parameter int DATA_W   = 64
) (
  input logic                clk,
  input logic                rst,
  input logic [N_AGENTS-1:0] agent_req,
  input logic [1:0]          agent_phase,
  input logic [N_AGENTS-1:0] agent_done,
  input logic                agent_run,
  input logic                mark_valid,
  input logic [DATA_W-1:0]   mark_data,
  input logic                mark_ready,
  input logic [EPOCH_W-1:0]  epoch
);

  // R2
  open_drain_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(agent_req) == '0 && agent_req != '0) |-> (agent_phase == 2'd0 && !agent_run));

  // R3
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    (agent_req != '0 && $past(agent_req) != '0 && agent_phase != $past(agent_phase))
      |-> (agent_phase == $past(agent_phase) + 2'd1));

  // R4
  phase_barrier_chk: assert property (@(posedge clk) disable iff (rst)
    (agent_phase != $past(agent_phase)) |-> ($past(agent_req & ~agent_done) == '0));

  // R5
  req_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (|(agent_req & ~$past(agent_req))) |-> (&agent_req));

  // R6
  mark_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mark_valid |-> (agent_req == '0 && !agent_run));

  // R6
  mark_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mark_valid && !mark_ready) |=> (mark_valid && $stable(mark_data) && $stable(epoch)));

  // R7
  epoch_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mark_valid && mark_ready)
      |=> (epoch == $past(epoch) + EPOCH_W'(1) && agent_run && !mark_valid));

  // R10
  run_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    agent_run |-> (agent_req == '0 && !mark_valid));

endmodule

bind ckpt_sequencer ckpt_sequencer_chk #(
  .N_AGENTS(N_AGENTS), .EPOCH_W(EPOCH_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .agent_req(agent_req), .agent_phase(agent_phase),
  .agent_done(agent_done), .agent_run(agent_run), .mark_valid(mark_valid),
  .mark_data(mark_data), .mark_ready(mark_ready), .epoch(epoch)
);

// File: tb/sim_ckpt_sequencer.sv
module sim_agent_resp (
  input  logic clk,
  input  logic en,
  input  logic req,
  input  int   dly,
  output logic done
);
  initial begin
    done = 1'b0;
    forever begin
      @(negedge clk);
      if (en && req) begin
        repeat (dly) @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
      end
    end
  end
endmodule

module sim_ckpt_sequencer;
  localparam int NA = 4;
  localparam int EW = 16;
  localparam int P  = 200;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam logic [AW-1:0] MA = 32'h0001_F000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ckpt_req = 1'b0;
  logic [NA-1:0] agent_req, man_done, auto_done, agent_done;
  logic [1:0] agent_phase;
  logic agent_run, mark_valid, mark_ready;
  logic [AW-1:0] mark_addr;
  logic [DW-1:0] mark_data;
  logic [EW-1:0] epoch;
  logic auto_en = 1'b0;
  int dly [NA];

  int checks = 0, fails = 0;
  int viol_run = 0, viol_mark = 0;
  int ph_log [8];
  int ph_n = 0;
  logic [DW-1:0] last_mark_data;
  logic [AW-1:0] last_mark_addr;

  always #4 clk = ~clk;

  assign agent_done = man_done | auto_done;

  ckpt_sequencer #(
    .N_AGENTS(NA), .EPOCH_W(EW), .EPOCH_CYCLES(P), .ADDR_W(AW), .DATA_W(DW), .MARK_ADDR(MA)
  ) u0 (
    .clk(clk), .rst(rst), .ckpt_req(ckpt_req), .agent_req(agent_req),
    .agent_phase(agent_phase), .agent_done(agent_done), .agent_run(agent_run),
    .mark_valid(mark_valid), .mark_addr(mark_addr), .mark_data(mark_data),
    .mark_ready(mark_ready), .epoch(epoch)
  );

  for (genvar g = 0; g < NA; g++) begin : g_agent
    sim_agent_resp u_resp (
      .clk(clk), .en(auto_en), .req(agent_req[g]), .dly(dly[g]), .done(auto_done[g])
    );
  end

  // Monitor, sampling between the input-drive edge and the clock edge.
  logic [NA-1:0] prev_req = '0;
  logic [1:0]    prev_ph  = '0;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (agent_run && (agent_req != '0 || mark_valid)) viol_run++;
      if (mark_valid && agent_req != '0) viol_mark++;
      if (agent_req != '0 && (prev_req == '0 || agent_phase != prev_ph)) begin
        if (ph_n < 8) ph_log[ph_n] = int'(agent_phase);
        ph_n++;
      end
      if (mark_valid && mark_ready) begin
        last_mark_data = mark_data;
        last_mark_addr = mark_addr;
      end
      prev_req = agent_req;
      prev_ph  = agent_phase;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); ckpt_req = 1'b1;
    @(negedge clk); ckpt_req = 1'b0;
  endtask

  task automatic pulse_done(input logic [NA-1:0] m);
    @(negedge clk); man_done = m;
    @(negedge clk); man_done = '0;
  endtask

  task automatic wait_run();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!agent_run && n < 3000);
    chk(agent_run, "R7", "agents released", agent_run, 1);
  endtask

  task automatic t_reset();
    chk(agent_run == 1'b1, "R1", "run after reset", agent_run, 1);
    chk(agent_req == '0, "R1", "req after reset", agent_req, 0);
    chk(!mark_valid, "R1", "mark_valid after reset", mark_valid, 0);
    chk(epoch == '0, "R1", "epoch after reset", epoch, 0);
  endtask

  task automatic t_basic();
    int e0 = int'(epoch);
    auto_en = 1'b1; mark_ready = 1'b1; ph_n = 0;
    @(negedge clk); ckpt_req = 1'b1;
    @(negedge clk); ckpt_req = 1'b0;
    chk(agent_req == '0 && agent_run, "R2", "no req one edge after sample", agent_req, 0);
    @(negedge clk);
    chk(agent_req == '1, "R2", "all req after second edge", agent_req, 15);
    chk(agent_phase == 2'd0 && !agent_run, "R2", "drain phase, run low", agent_phase, 0);
    wait_run();
    chk(ph_n == 3, "R3", "phase count", ph_n, 3);
    chk(ph_log[0] == 0 && ph_log[1] == 1 && ph_log[2] == 2, "R3", "phase order",
        ph_log[0] * 100 + ph_log[1] * 10 + ph_log[2], 12);
    chk(int'(epoch) == e0 + 1, "R7", "epoch step", epoch, e0 + 1);
    chk(last_mark_data == DW'(e0), "R6", "marker payload", last_mark_data, e0);
    chk(last_mark_addr == MA, "R6", "marker address", last_mark_addr, MA);
  endtask

  task automatic t_barrier();
    int e0 = int'(epoch);
    auto_en = 1'b0; mark_ready = 1'b1;
    @(negedge clk); ckpt_req = 1'b1;
    @(negedge clk); ckpt_req = 1'b0; man_done = '1;   // lands on the opening edge
    @(negedge clk); man_done = '0;
    chk(agent_req == '1, "R5", "done on opening edge ignored", agent_req, 15);
    pulse_done(4'b0001);
    chk(agent_req == 4'b1110, "R4", "own bit cleared", agent_req, 14);
    chk(agent_phase == 2'd0, "R4", "phase holds", agent_phase, 0);
    pulse_done(4'b0111);
    chk(agent_req == 4'b1000, "R5", "repeat done from idle agent ignored", agent_req, 8);
    chk(agent_phase == 2'd0, "R4", "phase holds with one missing", agent_phase, 0);
    pulse_done(4'b1000);
    chk(agent_req == '1 && agent_phase == 2'd1, "R4", "advance on last done",
        agent_phase, 1);
    pulse_done(4'b1111);
    chk(agent_req == '1 && agent_phase == 2'd2, "R3", "context phase", agent_phase, 2);
    pulse_done(4'b0111);
    chk(!mark_valid && agent_req == 4'b1000, "R6", "no marker before last done",
        mark_valid, 0);
    pulse_done(4'b1000);
    chk(mark_valid && agent_req == '0, "R6", "marker after last context done",
        mark_valid, 1);
    chk(mark_data == DW'(e0), "R6", "marker data", mark_data, e0);
    @(negedge clk);
    chk(agent_run && !mark_valid, "R7", "release on ack", agent_run, 1);
    chk(int'(epoch) == e0 + 1, "R7", "epoch after ack", epoch, e0 + 1);
  endtask

  task automatic t_marker_stall();
    int e0 = int'(epoch);
    int n = 0;
    logic [DW-1:0] d0;
    bit held = 1'b1;
    auto_en = 1'b1; mark_ready = 1'b0;
    pulse_req();
    while (!mark_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(mark_valid, "R6", "marker raised", mark_valid, 1);
    d0 = mark_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!mark_valid || mark_data != d0 || agent_run || int'(epoch) != e0) held = 1'b0;
    end
    chk(held, "R6", "marker held while not ready", held, 1);
    chk(d0 == DW'(e0), "R6", "stalled marker data", d0, e0);
    mark_ready = 1'b1;
    @(negedge clk);
    chk(agent_run && !mark_valid, "R7", "release on delayed ack", agent_run, 1);
    chk(int'(epoch) == e0 + 1, "R7", "epoch on delayed ack", epoch, e0 + 1);
  endtask

  task automatic t_timer();
    int n = 0;
    auto_en = 1'b1; mark_ready = 1'b1;
    pulse_req();
    wait_run();
    while (agent_run && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == P + 1, "R8", "run cycles before auto checkpoint", n, P + 1);
    chk(agent_req == '1 && agent_phase == 2'd0, "R8", "auto drain requests", agent_req, 15);
    wait_run();
  endtask

  task automatic t_pending();
    int e0 = int'(epoch);
    int n = 0;
    auto_en = 1'b1; mark_ready = 1'b1;
    pulse_req();
    while (!(agent_phase == 2'd1 && agent_req != '0) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    pulse_req();
    repeat (2) @(negedge clk);
    chk(agent_phase != 2'd0 && !agent_run, "R9", "no restart to drain", agent_phase, 1);
    wait_run();
    n = 0;
    while (agent_run && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == 1, "R9", "one run cycle before held checkpoint", n, 1);
    chk(agent_req == '1 && agent_phase == 2'd0, "R9", "held checkpoint opens", agent_req, 15);
    wait_run();
    chk(int'(epoch) == e0 + 2, "R9", "two epochs closed", epoch, e0 + 2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    man_done = '0;
    mark_ready = 1'b1;
    dly[0] = 1; dly[1] = 3; dly[2] = 0; dly[3] = 5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_barrier();
    t_marker_stall();
    t_pending();
    t_timer();
    chk(viol_run == 0, "R10", "run with outstanding work", viol_run, 0);
    chk(viol_mark == 0, "R6", "marker during requests", viol_mark, 0);
    finish_run();
  end
endmodule